// File: doc/BRIEF.md
# Reloadable Pulse Count Divider

The block counts pulses on a one-bit input stream and raises its output on exactly one pulse out of every N. N is a stored divisor. A restart strobe loads a new value from the divisor input, and the count then begins a new period. The output is a combinational function of the current input pulse and the stored count, so it rises in the same cycle as the pulse it answers. This lets it drive the ready signal of a one-entry buffer, so that each buffered item is emitted N times.

A stored divisor of zero is allowed. While it is zero, the output stays low, input pulses are not counted, and a status flag is raised. The block takes the first non-zero value that appears on the divisor input, with or without a restart, and counts from the start of a period with it. The divisor is an exact count, not a zero-based index: a divisor of 1 fires on every pulse. At reset the divisor takes a parameter value.

Top module: `pulse_count_divider`

## Requirements
- R1: While `rst_n` is low, the stored divisor takes the value `INIT_DIVISOR` and the count goes to the start of a period. The first `pulse_out` after reset comes with the `INIT_DIVISOR`-th pulse.
- R2: When `restart` is high at a clock edge, the value on `divisor` is stored and the count goes back to the start of a period. The new divisor is in effect from the next cycle. While the stored divisor is non-zero, a change on `divisor` without `restart` has no effect.
- R3: `pulse_out` is high only in a cycle where `pulses_in` is high. There is no cycle of latency between the two.
- R4: With a stored divisor D of at least 1, `pulse_out` is high on every D-th counted pulse, and periods follow each other with no gap. With D = 1 every pulse fires.
- R5: A cycle with `restart` high never raises `pulse_out`, and a pulse in that cycle does not count toward the new period.
- R6: `div_by_zero` is high exactly when the stored divisor is zero. While it is high, `pulse_out` stays low and pulses are not counted.
- R7: While the stored divisor is zero, the first cycle with a non-zero value on `divisor` stores that value and starts a new period. A pulse in that cycle is not counted.
- R8: Cycles with `pulses_in` low do not advance the count. The largest divisor that fits in `DIV_W` bits (2^`DIV_W`−1) works like any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| restart | input | 1 | Strobe that loads `divisor` and restarts the period |
| divisor | input | DIV_W | Pulses per output pulse, as an exact count |
| pulses_in | input | 1 | Input pulse stream, one pulse per high cycle |
| pulse_out | output | 1 | High on the pulse that ends each period |
| div_by_zero | output | 1 | Stored divisor is zero |

## Verification
The stimulus covers these cases:
- Divisors of 1, 2, an odd middle value and the largest value. These separate an off-by-one period from a correct one, and show whether the terminal compare fails at full width.
- Pulse streams with gaps, and a pseudo-random pulse pattern. These show whether idle cycles advance the count by mistake.
- A restart in the middle of a period, a restart together with a pulse, and a change on the divisor input without a restart. These tell a count that is cleared correctly from one that leaks across a reload.
- A zero restart, followed by pulses and then a non-zero value with a pulse in the same cycle. This tells whether zero is held, and whether the adopting cycle counts its pulse.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
    // Action applied to the period counter in a given cycle
    typedef enum logic [1:0] {
        CNT_HOLD  = 2'd0,
        CNT_CLEAR = 2'd1,
        CNT_STEP  = 2'd2
    } cnt_act_e;
endpackage

// File: rtl/pcd_divisor_store.sv
module pcd_divisor_store #(
    parameter int unsigned DIV_W        = 8,
    parameter int unsigned INIT_DIVISOR = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic [DIV_W-1:0] div_q,
    output logic             zero,
    output logic             load
);
    localparam logic [DIV_W-1:0] INIT_VAL = DIV_W'(INIT_DIVISOR);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        zero = (st_q.div == '0);
        // a restart always reloads; a zero store adopts any non-zero value
        load = restart | (zero & (|divisor));
        if (load) begin
            st_d.div = divisor;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.div <= INIT_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_q = st_q.div;
endmodule

// File: rtl/pcd_period_counter.sv
module pcd_period_counter
    import pcd_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_act_e         act,
    input  logic [DIV_W-1:0] div_q,
    output logic             at_end
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } count_t;

    count_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        // last pulse of the period is the one seen when cnt == div-1
        at_end = (div_q != '0) && (st_q.cnt == div_q - ONE);
        unique case (act)
            CNT_CLEAR: st_d.cnt = '0;
            CNT_STEP:  st_d.cnt = at_end ? '0 : st_q.cnt + ONE;
            default:   st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pulse_count_divider.sv
module pulse_count_divider
    import pcd_pkg::*;
#(
    parameter int unsigned DIV_W        = 8,
    parameter int unsigned INIT_DIVISOR = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    input  logic             pulses_in,
    output logic             pulse_out,
    output logic             div_by_zero
);
    logic [DIV_W-1:0] div_q;
    logic             zero;
    logic             load;
    logic             at_end;
    cnt_act_e         act;

    pcd_divisor_store #(
        .DIV_W        (DIV_W),
        .INIT_DIVISOR (INIT_DIVISOR)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .divisor (divisor),
        .div_q   (div_q),
        .zero    (zero),
        .load    (load)
    );

    pcd_period_counter #(
        .DIV_W (DIV_W)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act),
        .div_q  (div_q),
        .at_end (at_end)
    );

    always_comb begin
        // a reload wins over a pulse in the same cycle
        if (load) begin
            act = CNT_CLEAR;
        end else if (pulses_in && !zero) begin
            act = CNT_STEP;
        end else begin
            act = CNT_HOLD;
        end
        pulse_out   = pulses_in && !load && !zero && at_end;
        div_by_zero = zero;
    end
endmodule

// File: rtl/pulse_count_divider_chk.sv
module pulse_count_divider_chk #(
    parameter int unsigned DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             restart,
    input logic [DIV_W-1:0] divisor,
    input logic             pulses_in,
    input logic             pulse_out,
    input logic             div_by_zero,
    input logic [DIV_W-1:0] div_q
);
    // R3
    out_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> pulses_in);

    // R5
    restart_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !pulse_out);

    // R2
    restart_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (div_q == $past(divisor)));

    // R6
    zero_blocks_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_by_zero |-> !pulse_out);

    // R6
    zero_flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_by_zero == (div_q == '0));

    // R7
    zero_adopts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_by_zero && !restart && (divisor != '0)) |=> !div_by_zero);

    // R4
    unit_every_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((div_q == DIV_W'(1)) && pulses_in && !restart) |-> pulse_out);
endmodule

bind pulse_count_divider pulse_count_divider_chk #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .divisor     (divisor),
    .pulses_in   (pulses_in),
    .pulse_out   (pulse_out),
    .div_by_zero (div_by_zero),
    .div_q       (div_q)
);

// File: tb/pulse_count_divider_test.sv
module pulse_count_divider_test;
    localparam int W    = 4;
    localparam int INIT = 3;

    typedef struct {
        logic  po;
        logic  dz;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         restart = 1'b0;
    logic [W-1:0] divisor = '0;
    logic         pulses_in = 1'b0;
    logic         pulse_out;
    logic         div_by_zero;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    exp_t sb[$];

    // reference state, derived from the requirements
    int m_div = INIT;
    int m_cnt = 0;

    pulse_count_divider #(.DIV_W(W), .INIT_DIVISOR(INIT)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .divisor     (divisor),
        .pulses_in   (pulses_in),
        .pulse_out   (pulse_out),
        .div_by_zero (div_by_zero)
    );

    always #4 clk = ~clk;

    task automatic step(input logic r, input int d, input logic p, input string tag);
        exp_t e;
        bit   ld;
        @(negedge clk);
        restart   = r;
        divisor   = W'(d);
        pulses_in = p;
        ld    = r || (m_div == 0 && d != 0);
        e.po  = p && !ld && m_div != 0 && m_cnt == m_div - 1;
        e.dz  = (m_div == 0);
        e.tag = tag;
        sb.push_back(e);
        if (ld) begin
            m_div = d;
            m_cnt = 0;
        end else if (p && m_div != 0) begin
            m_cnt = (m_cnt == m_div - 1) ? 0 : m_cnt + 1;
        end
    endtask

    // monitor: compare outputs mid-cycle against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (pulse_out !== e.po || div_by_zero !== e.dz) begin
                    bad++;
                    $display("FAIL %s: pulse_out=%b div_by_zero=%b expected %b %b",
                             e.tag, pulse_out, div_by_zero, e.po, e.dz);
                end
            end
        end
    end

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                bad++;
                total++;
                $display("FAIL watchdog: cycles=%0d expected < 50000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] lfsr;
        int d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        total++;
        // R1: reset state, stored divisor is the non-zero initial value
        if (pulse_out !== 1'b0 || div_by_zero !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: pulse_out=%b div_by_zero=%b expected 0 0",
                     pulse_out, div_by_zero);
        end
        // R1: initial divisor, with idle gaps (R8)
        step(0, 0, 1, "R1");
        step(0, 0, 0, "R8 gap");
        step(0, 0, 1, "R1");
        step(0, 0, 0, "R8 gap");
        step(0, 0, 1, "R1 third pulse");
        for (int i = 0; i < 6; i++) step(0, 0, 1, "R4 initial periods");
        // R2/R4: divisor 1
        step(1, 1, 0, "R2 load 1");
        for (int i = 0; i < 4; i++) step(0, 1, 1, "R4 div1");
        // R5: restart with pulse, divisor 2
        step(1, 2, 1, "R5 restart+pulse");
        for (int i = 0; i < 5; i++) step(0, 2, 1, "R4 div2");
        // R2: divisor changes without restart are ignored
        for (int i = 0; i < 6; i++) step(0, 5, 1, "R2 no restart");
        // R8: maximum divisor
        step(1, 15, 0, "R8 load max");
        for (int i = 0; i < 32; i++) step(0, 15, 1, "R8 max");
        // R2: restart in the middle of a period
        step(1, 4, 0, "R2 load 4");
        step(0, 4, 1, "R2 mid");
        step(0, 4, 1, "R2 mid");
        step(1, 3, 0, "R2 mid restart");
        for (int i = 0; i < 7; i++) step(0, 3, 1, "R2 after mid restart");
        // R6: zero divisor
        step(1, 0, 0, "R6 load zero");
        for (int i = 0; i < 4; i++) step(0, 0, 1, "R6 zero held");
        // R7: non-zero adopted without restart, pulse in that cycle not counted
        step(0, 6, 1, "R7 adopt");
        for (int i = 0; i < 13; i++) step(0, 6, 1, "R7 after adopt");
        // R7: zero via restart, then adopt through a restart with pulse
        step(1, 0, 1, "R6 zero with pulse");
        step(1, 2, 1, "R7 restart adopt");
        for (int i = 0; i < 4; i++) step(0, 2, 1, "R7 div2");
        // R4/R8: pseudo-random pulse pattern on several divisors
        lfsr = 8'hA5;
        d = 3;
        step(1, d, 0, "R4 random load");
        for (int i = 0; i < 80; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (i == 40) begin
                d = 7;
                step(1, d, lfsr[0], "R5 random restart");
            end else begin
                step(0, d, lfsr[0], "R4 random");
            end
        end
        step(0, d, 0, "R8 idle");
        @(negedge clk);
        #3;
        wait (sb.size() == 0);
        @(negedge clk);
        #3;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule